// File: doc/BRIEF.md
# Microstep Phase Position Sequencer

This block holds the 6-bit electrical phase position of a two-phase stepper driver. The position runs from 0 to 63 over one electrical revolution. It moves in one of five step resolutions: sixteenth, eighth, quarter (mini), half and full. A downstream current-reference lookup reads the committed position, and a host reads it back through a separate readback output.

The position has two update sources. In pin mode, every rising edge of an asynchronous step input moves the target by one step of the selected resolution, in the selected direction. In register mode, a write port loads a new target. Neither source changes the committed position directly. The target is staged and becomes effective only on the strobe that marks the start of the next PWM cycle. A forced hold freezes the position against both sources. The hold is active when auto-hold-on-stall is enabled and the stall flag is set.

Top module: `ustep_phase_seq`

## Requirements
- R1: After a synchronous active-high reset, `phase` and `rd_phase` read 0 and no update is pending.
- R2: In pin mode with `motor_en`=1, each step edge moves the target by the step size of `step_mode`: 0 gives ±1, 1 gives ±2, 2 gives ±4, 3 gives ±8 and 4 gives ±16. Codes 5 to 7 behave as code 0. `dir`=0 increments and `dir`=1 decrements.
- R3: Positions wrap modulo 64 in both directions. In full-step mode the only legal positions are 8, 24, 40 and 56, so 56 goes up to 8 and 8 goes down to 56.
- R4: When the current position is not legal for the selected mode, the next step moves to the nearest legal position in the step direction. This move can be shorter than a full step. For example, mini mode goes from 2 up to 4. The mode in force at each edge is the one used.
- R5: In pin mode, step edges are ignored while `motor_en`=0.
- R6: In register mode, `wr_en` loads `wr_phase` as the target even when `motor_en`=0. Step edges are ignored in register mode. Writes are ignored in pin mode.
- R7: `phase` and `rd_phase` change only on a cycle where `pwm_start`=1. Until then they return the previous committed value.
- R8: While `hold_on_stall_en` and `stall_flag` are both 1, no step edge, no write and no commit changes the target or the committed position. A target staged before the hold commits after the hold is released.
- R9: Every step edge is counted. Several edges between two PWM cycle starts accumulate into a single pending target.
- R10: A step input held high produces exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | 1 | Asynchronous step pulse input |
| step_mode | input | 3 | Step resolution select |
| dir | input | 1 | 0 = up, 1 = down |
| motor_en | input | 1 | Motor enable; gates pin-mode steps |
| pin_mode | input | 1 | 1 = pin updates, 0 = register updates |
| wr_en | input | 1 | Register write strobe |
| wr_phase | input | 6 | Written target position |
| hold_on_stall_en | input | 1 | Auto-hold-on-stall enable |
| stall_flag | input | 1 | Stall detected |
| pwm_start | input | 1 | PWM cycle start strobe |
| phase | output | 6 | Committed phase position |
| rd_phase | output | 6 | Readback of the committed position |

## Verification
Some properties are checked on every cycle. The committed position never moves without a PWM cycle start. The hold freezes both the staged target and the committed value. A disabled motor freezes the target in pin mode. Each detected edge is a single-cycle pulse. After any full-step move the target sits at an offset of 8 within its 16-position group, and after any eighth-step move it is even.

Other behaviour can only be shown by the directed scenarios against hand-derived positions. These cover the exact step distance in each mode, wrap-around in both directions, the shortened snap move after a switch to a coarser mode, the accumulation of several edges before one commit, and the release of a target that was held back.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    localparam int PHASE_W = 6;

    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic [2:0] {
        SM_SIXTEENTH = 3'd0,
        SM_EIGHTH    = 3'd1,
        SM_QUARTER   = 3'd2,
        SM_HALF      = 3'd3,
        SM_FULL      = 3'd4
    } step_mode_e;

    // Step size minus one for a mode code; unused codes act as finest.
    function automatic phase_t step_mask(input logic [2:0] mode);
        case (mode)
            SM_EIGHTH:  return phase_t'(1);
            SM_QUARTER: return phase_t'(3);
            SM_HALF:    return phase_t'(7);
            SM_FULL:    return phase_t'(15);
            default:    return phase_t'(0);
        endcase
    endfunction

    // Offset of the legal grid: full step sits half a step off zero.
    function automatic phase_t grid_offset(input logic [2:0] mode);
        return (mode == SM_FULL) ? phase_t'(8) : phase_t'(0);
    endfunction

    // Next legal position in the step direction; snaps when off-grid.
    function automatic phase_t next_pos(input phase_t pos,
                                        input logic [2:0] mode,
                                        input logic down);
        phase_t msk;
        phase_t off;
        phase_t rel;
        phase_t res;
        msk = step_mask(mode);
        off = grid_offset(mode);
        rel = pos - off;
        if (!down)
            res = (rel & ~msk) + (msk + phase_t'(1));
        else
            res = (rel - phase_t'(1)) & ~msk;
        return res + off;
    endfunction

endpackage

// File: rtl/ustep_edge_sync.sv
module ustep_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= 1'b0;
                else if (i == 0)
                    chain[i] <= async_in;
                else
                    chain[i] <= chain[(i > 0) ? i-1 : 0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= 1'b0;
        else
            last_q <= chain[STAGES-1];
    end

    assign rise_pulse = chain[STAGES-1] & ~last_q;

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/ustep_stage.sv
module ustep_stage
    import ustep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step_evt,
    input  logic [2:0] step_mode,
    input  logic       dir,
    input  logic       motor_en,
    input  logic       pin_mode,
    input  logic       wr_en,
    input  phase_t     wr_phase,
    input  logic       hold,
    input  logic       commit,
    output phase_t     staged,
    output logic       pending
);
    logic   pin_evt;
    logic   reg_evt;
    phase_t stepped;

    assign pin_evt = pin_mode & motor_en & ~hold & step_evt;
    assign reg_evt = ~pin_mode & wr_en & ~hold;
    assign stepped = next_pos(staged, step_mode, dir);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged  <= '0;
            pending <= 1'b0;
        end else begin
            if (pin_evt)
                staged <= stepped;
            else if (reg_evt)
                staged <= wr_phase;
            if (pin_evt | reg_evt)
                pending <= 1'b1;
            else if (commit)
                pending <= 1'b0;
        end
    end

    // R5
    disabled_motor_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_mode && !motor_en) |=> $stable(staged));
    // R8
    hold_stage_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(staged));
    // R3
    full_grid_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_evt && step_mode == SM_FULL) |=> (staged[3:0] == 4'd8));
    // R2
    eighth_grid_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_evt && step_mode == SM_EIGHTH) |=> !staged[0]);
    // R6
    write_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!pin_mode && wr_en && !hold) |=> (staged == $past(wr_phase)));

endmodule

// File: rtl/ustep_commit.sv
module ustep_commit
    import ustep_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pwm_start,
    input  logic   hold,
    input  logic   pending,
    input  phase_t staged,
    output logic   commit,
    output phase_t phase_q
);
    assign commit = pwm_start & pending & ~hold;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (commit)
            phase_q <= staged;
    end

    // R7
    cycle_start_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase_q) |-> $past(pwm_start));
    // R8
    hold_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm_start && hold) |=> $stable(phase_q));

endmodule

// File: rtl/ustep_phase_seq.sv
module ustep_phase_seq
    import ustep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step_in,
    input  logic [2:0] step_mode,
    input  logic       dir,
    input  logic       motor_en,
    input  logic       pin_mode,
    input  logic       wr_en,
    input  logic [5:0] wr_phase,
    input  logic       hold_on_stall_en,
    input  logic       stall_flag,
    input  logic       pwm_start,
    output logic [5:0] phase,
    output logic [5:0] rd_phase
);
    logic   step_evt;
    logic   hold;
    logic   commit;
    logic   pending;
    phase_t staged;
    phase_t phase_q;

    assign hold = hold_on_stall_en & stall_flag;

    ustep_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_in   (step_in),
        .rise_pulse (step_evt)
    );

    ustep_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .step_evt  (step_evt),
        .step_mode (step_mode),
        .dir       (dir),
        .motor_en  (motor_en),
        .pin_mode  (pin_mode),
        .wr_en     (wr_en),
        .wr_phase  (wr_phase),
        .hold      (hold),
        .commit    (commit),
        .staged    (staged),
        .pending   (pending)
    );

    ustep_commit u_commit (
        .clk       (clk),
        .rst       (rst),
        .pwm_start (pwm_start),
        .hold      (hold),
        .pending   (pending),
        .staged    (staged),
        .commit    (commit),
        .phase_q   (phase_q)
    );

    assign phase    = phase_q;
    assign rd_phase = phase_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        $past(rst) |-> (phase == '0 && !pending));

endmodule

// File: tb/ustep_phase_seq_bench.sv
module ustep_phase_seq_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       step_in;
    logic [2:0] step_mode;
    logic       dir;
    logic       motor_en;
    logic       pin_mode;
    logic       wr_en;
    logic [5:0] wr_phase;
    logic       hold_on_stall_en;
    logic       stall_flag;
    logic       pwm_start;
    logic [5:0] phase;
    logic [5:0] rd_phase;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ustep_phase_seq u_ustep_phase_seq (
        .clk(clk), .rst(rst), .step_in(step_in), .step_mode(step_mode),
        .dir(dir), .motor_en(motor_en), .pin_mode(pin_mode), .wr_en(wr_en),
        .wr_phase(wr_phase), .hold_on_stall_en(hold_on_stall_en),
        .stall_flag(stall_flag), .pwm_start(pwm_start),
        .phase(phase), .rd_phase(rd_phase)
    );

    task automatic chk(input string req, input logic [5:0] exp);
        total++;
        if (phase !== exp || rd_phase !== exp) begin
            bad++;
            $display("FAIL %s: phase=%0d rd_phase=%0d expected=%0d", req, phase, rd_phase, exp);
        end
    endtask

    task automatic pulse_step(input int high_cycles);
        @(negedge clk) step_in = 1'b1;
        repeat (high_cycles) @(negedge clk);
        step_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic cycle_start();
        @(negedge clk) pwm_start = 1'b1;
        @(negedge clk) pwm_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(input logic [5:0] p);
        pin_mode = 1'b0;
        @(negedge clk) begin wr_en = 1'b1; wr_phase = p; end
        @(negedge clk) wr_en = 1'b0;
        cycle_start();
        pin_mode = 1'b1;
    endtask

    task automatic one_step(input logic [2:0] m, input logic d);
        step_mode = m; dir = d;
        pulse_step(4);
        cycle_start();
    endtask

    task automatic t_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset value", 6'd0);
        cycle_start();
        chk("R1 nothing pending", 6'd0);
    endtask

    task automatic t_accumulate();
        step_mode = 3'd0; dir = 1'b0;
        for (int i = 0; i < 3; i++) pulse_step(2);
        chk("R7 readback before cycle start", 6'd0);
        cycle_start();
        chk("R9 three edges in one cycle", 6'd3);
    endtask

    task automatic t_sizes();
        load(6'd16); one_step(3'd1, 1'b0); chk("R2 eighth up", 6'd18);
        load(6'd16); one_step(3'd2, 1'b1); chk("R2 quarter down", 6'd12);
        load(6'd16); one_step(3'd3, 1'b0); chk("R2 half up", 6'd24);
        load(6'd24); one_step(3'd4, 1'b0); chk("R2 full up", 6'd40);
        load(6'd16); one_step(3'd6, 1'b1); chk("R2 unused code as sixteenth", 6'd15);
    endtask

    task automatic t_wrap();
        load(6'd0);  one_step(3'd0, 1'b1); chk("R3 wrap down", 6'd63);
        one_step(3'd0, 1'b0);              chk("R3 wrap up", 6'd0);
        load(6'd56); one_step(3'd4, 1'b0); chk("R3 full 56 up", 6'd8);
        one_step(3'd4, 1'b1);              chk("R3 full 8 down", 6'd56);
    endtask

    task automatic t_snap();
        load(6'd2);  one_step(3'd2, 1'b0); chk("R4 snap quarter up", 6'd4);
        one_step(3'd2, 1'b0);              chk("R4 then full quarter step", 6'd8);
        load(6'd5);  one_step(3'd3, 1'b1); chk("R4 snap half down", 6'd0);
        load(6'd9);  one_step(3'd4, 1'b0); chk("R4 snap full up", 6'd24);
        load(6'd0);  one_step(3'd4, 1'b0); chk("R4 full from zero", 6'd8);
    endtask

    task automatic t_disabled();
        load(6'd10);
        motor_en = 1'b0;
        one_step(3'd0, 1'b0);
        chk("R5 edge ignored when disabled", 6'd10);
        motor_en = 1'b1;
    endtask

    task automatic t_register();
        motor_en = 1'b0;
        load(6'd33);
        chk("R6 write with motor disabled", 6'd33);
        motor_en = 1'b1;
        pin_mode = 1'b0;
        step_mode = 3'd0; dir = 1'b0;
        pulse_step(4); cycle_start();
        chk("R6 edge ignored in register mode", 6'd33);
        pin_mode = 1'b1;
        @(negedge clk) begin wr_en = 1'b1; wr_phase = 6'd50; end
        @(negedge clk) wr_en = 1'b0;
        cycle_start();
        chk("R6 write ignored in pin mode", 6'd33);
    endtask

    task automatic t_hold();
        load(6'd20);
        hold_on_stall_en = 1'b1; stall_flag = 1'b1;
        one_step(3'd0, 1'b0);
        chk("R8 step blocked by hold", 6'd20);
        pin_mode = 1'b0;
        @(negedge clk) begin wr_en = 1'b1; wr_phase = 6'd44; end
        @(negedge clk) wr_en = 1'b0;
        cycle_start();
        pin_mode = 1'b1;
        chk("R8 write blocked by hold", 6'd20);
        stall_flag = 1'b0;
        pulse_step(4);
        stall_flag = 1'b1;
        cycle_start();
        chk("R8 commit blocked by hold", 6'd20);
        stall_flag = 1'b0;
        cycle_start();
        chk("R8 staged commits after release", 6'd21);
        hold_on_stall_en = 1'b0;
    endtask

    task automatic t_level();
        load(6'd30);
        step_mode = 3'd0; dir = 1'b0;
        pulse_step(40);
        cycle_start();
        chk("R10 long level counts once", 6'd31);
    endtask

    initial begin
        rst = 1'b1; step_in = 1'b0; step_mode = 3'd0; dir = 1'b0;
        motor_en = 1'b1; pin_mode = 1'b1; wr_en = 1'b0; wr_phase = '0;
        hold_on_stall_en = 1'b0; stall_flag = 1'b0; pwm_start = 1'b0;
        t_reset();
        t_accumulate();
        t_sizes();
        t_wrap();
        t_snap();
        t_disabled();
        t_register();
        t_hold();
        t_level();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule